// File: doc/BRIEF.md
# DMA Bus Hold Arbiter

This block sits between a set of peripheral DMA request lines and the host processor's bus ownership handshake. When at least one unmasked channel asks for service, it raises a hold request. It then waits for the processor to answer with hold acknowledge. Once the bus is released, it picks one channel, drives that channel's active-low acknowledge and pulses a start strobe to the transfer engine. It reports the selected channel index alongside the strobe.

The granted channel keeps the bus until the engine reports done. At that point the arbiter either moves straight to the next pending channel while keeping the hold, or drops the hold request. After dropping it, the arbiter waits for the processor to withdraw hold acknowledge before it may ask again. A channel input can also be fed from a downstream controller's hold request, with the matching acknowledge returned as that controller's hold acknowledge. This lets controllers be stacked.

Top module: `dma_hold_arbiter`

## Requirements
- R1: After reset, `hold_req` is 0, every bit of `dack_n` is 1 and `xfer_start` is 0.
- R2: While idle with `hold_ack` low, `hold_req` rises on the clock edge after any channel has `dreq[i]=1` and `dmask[i]=0`. A channel with `dmask[i]=1` never causes a hold request.
- R3: No `dack_n` bit goes low while `hold_ack` is low, even if `hold_req` has been high for several cycles.
- R4: On the first edge where `hold_ack` is high and a request is pending, the lowest-numbered unmasked requesting channel i is granted. From then on `dack_n` equals all ones except bit i = 0, `xfer_chan` = i, and `xfer_start` is 1 for exactly one cycle.
- R5: A granted channel keeps its acknowledge and `xfer_chan` unchanged until `xfer_done`, regardless of changes on `dreq` or `dmask`.
- R6: On the edge that samples `xfer_done` = 1 with no unmasked request pending, the acknowledge returns high and `hold_req` falls.
- R7: On the edge that samples `xfer_done` = 1 with an unmasked request pending, the highest-priority pending channel is granted at once, `hold_req` stays high and `xfer_start` pulses again.
- R8: After `hold_req` falls, it stays low while `hold_ack` is still high, even with requests pending. It may rise again only on an edge where `hold_ack` is low.
- R9: If `hold_ack` drops during service, all `dack_n` bits go high in the same cycle without waiting for a clock edge, and the grant reappears when `hold_ack` returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dreq | input | NCH | Per-channel request, active high |
| dmask | input | NCH | Per-channel mask, 1 = ignore request |
| hold_req | output | 1 | Bus hold request to the processor |
| hold_ack | input | 1 | Bus released by the processor |
| dack_n | output | NCH | Per-channel acknowledge, active low |
| xfer_start | output | 1 | One-cycle strobe telling the engine to begin |
| xfer_chan | output | $clog2(NCH) | Index of the granted channel |
| xfer_done | input | 1 | Engine reports end of service for the granted channel |

## Verification
`hold_req`, `xfer_start`, `xfer_chan`, and the grant-state part of `dack_n` all come from registers. Each is due one edge after the input that causes it, so the bench drives on the falling edge and samples on the following falling edge. The gating of `dack_n` by `hold_ack` is combinational, so R9 is sampled in the same half cycle the bench changes `hold_ack`. The bench sweeps all 256 request/mask combinations. Each combination runs through the request, wait, grant, hold and release stages, with the expected channel computed as the lowest set bit of `dreq & ~dmask`.

// File: rtl/dma_hold_arbiter.sv
module dma_hold_arbiter #(
  parameter int NCH = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NCH-1:0]         dreq,
  input  logic [NCH-1:0]         dmask,
  output logic                   hold_req,
  input  logic                   hold_ack,
  output logic [NCH-1:0]         dack_n,
  output logic                   xfer_start,
  output logic [$clog2(NCH)-1:0] xfer_chan,
  input  logic                   xfer_done
);
  localparam int CW = $clog2(NCH);

  typedef enum logic [1:0] {IDLE, WAITACK, SERVE, RELEASE} st_t;
  st_t state;

  logic [NCH-1:0] pend;
  logic [CW-1:0]  pick;
  logic           any;
  logic           serving;

  assign pend    = dreq & ~dmask;
  assign any     = |pend;
  assign serving = (state == SERVE);

  always_comb begin
    pick = '0;
    for (int i = NCH - 1; i >= 0; i--)
      if (pend[i]) pick = CW'(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= IDLE;
      hold_req   <= 1'b0;
      xfer_start <= 1'b0;
      xfer_chan  <= '0;
    end else begin
      xfer_start <= 1'b0;
      case (state)
        IDLE:
          if (any && !hold_ack) begin
            hold_req <= 1'b1;
            state    <= WAITACK;
          end
        WAITACK:
          if (hold_ack) begin
            if (any) begin
              xfer_chan  <= pick;
              xfer_start <= 1'b1;
              state      <= SERVE;
            end else begin
              hold_req <= 1'b0;
              state    <= RELEASE;
            end
          end
        SERVE:
          if (xfer_done) begin
            if (any) begin
              xfer_chan  <= pick;
              xfer_start <= 1'b1;
            end else begin
              hold_req <= 1'b0;
              state    <= RELEASE;
            end
          end
        RELEASE:
          if (!hold_ack) state <= IDLE;
        default: state <= IDLE;
      endcase
    end
  end

  assign dack_n = ~({NCH{serving & hold_ack}} & (NCH'(1) << xfer_chan));

  assert_ack_needs_bus_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (~dack_n != '0) |-> (hold_ack && hold_req));

  assert_single_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~dack_n));

  assert_start_one_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |=> !xfer_start);

  assert_grant_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (serving && !xfer_done) |=> $stable(xfer_chan));

  assert_release_on_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (serving && xfer_done && !any) |=> !hold_req);

  assert_rerequest_after_ack_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_req) |-> !$past(hold_ack));
endmodule

// File: tb/test_dma_hold_arbiter.sv
module test_dma_hold_arbiter;
  localparam int NCH = 4;

  logic clk = 0;
  logic rst_n = 0;
  logic [NCH-1:0] dreq = '0;
  logic [NCH-1:0] dmask = '0;
  logic hold_ack = 0;
  logic xfer_done = 0;
  logic hold_req;
  logic [NCH-1:0] dack_n;
  logic xfer_start;
  logic [1:0] xfer_chan;

  int checks = 0;
  int fails = 0;
  bit ended = 0;

  always #10 clk = ~clk;

  dma_hold_arbiter #(.NCH(NCH)) i_dma_hold_arbiter (
    .clk(clk), .rst_n(rst_n), .dreq(dreq), .dmask(dmask),
    .hold_req(hold_req), .hold_ack(hold_ack), .dack_n(dack_n),
    .xfer_start(xfer_start), .xfer_chan(xfer_chan), .xfer_done(xfer_done)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  function automatic int low_bit(input logic [3:0] p);
    for (int i = 0; i < 4; i++) if (p[i]) return i;
    return -1;
  endfunction

  initial begin
    step();
    chk("R1 hold_req", hold_req, 0);
    chk("R1 dack_n", dack_n, 4'hF);
    chk("R1 xfer_start", xfer_start, 0);
    rst_n = 1;
    step();

    for (int r = 0; r < 16; r++) begin
      for (int m = 0; m < 16; m++) begin
        logic [3:0] p;
        int idx;
        p = 4'(r) & ~4'(m);
        idx = low_bit(p);
        dreq = 4'(r); dmask = 4'(m);
        step();
        chk("R2 hold_req after request", hold_req, (p != 0));
        chk("R3 no ack before hold_ack", dack_n, 4'hF);
        if (p != 0) begin
          step();
          chk("R3 still no ack", dack_n, 4'hF);
          hold_ack = 1;
          step();
          chk("R4 dack_n grant", dack_n, ~(4'b1 << idx) & 4'hF);
          chk("R4 xfer_chan", xfer_chan, idx);
          chk("R4 start pulse", xfer_start, 1);
          dreq = 4'hF; dmask = 4'h0;
          step();
          chk("R4 start one cycle", xfer_start, 0);
          dreq = 4'h0;
          step();
          chk("R5 grant held", dack_n, ~(4'b1 << idx) & 4'hF);
          chk("R5 chan held", xfer_chan, idx);
          xfer_done = 1;
          step();
          xfer_done = 0;
          chk("R6 ack released", dack_n, 4'hF);
          chk("R6 hold dropped", hold_req, 0);
          dreq = 4'h1;
          step();
          chk("R8 no rerequest with hold_ack high", hold_req, 0);
          step();
          chk("R8 no rerequest with hold_ack high", hold_req, 0);
          hold_ack = 0;
          step();
          step();
          chk("R8 rerequest after hold_ack low", hold_req, 1);
          dreq = 4'h0;
          hold_ack = 1;
          step();
          chk("R8 empty grant releases", hold_req, 0);
          hold_ack = 0;
          step();
        end
        dreq = 4'h0; dmask = 4'h0;
        step();
      end
    end

    dreq = 4'b0101; dmask = 4'h0;
    step();
    hold_ack = 1;
    step();
    chk("R4 priority 0 over 2", xfer_chan, 0);
    dreq = 4'b0100;
    step();
    xfer_done = 1;
    step();
    xfer_done = 0;
    chk("R7 next channel", xfer_chan, 2);
    chk("R7 next ack", dack_n, 4'b1011);
    chk("R7 hold kept", hold_req, 1);
    chk("R7 start again", xfer_start, 1);
    #2 hold_ack = 0;
    #1 chk("R9 ack gated off", dack_n, 4'hF);
    #2 hold_ack = 1;
    #1 chk("R9 ack returns", dack_n, 4'b1011);
    dreq = 4'h0;
    step();
    xfer_done = 1;
    step();
    xfer_done = 0;
    chk("R6 release after last", hold_req, 0);
    hold_ack = 0;
    step();
    rst_n = 0;
    step();
    chk("R1 reset again", dack_n, 4'hF);
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule